// File: doc/BRIEF.md
# Link Receiver Acknowledgement Controller

This block sits on the receive side of a point-to-point packet link. Every packet on the link carries a 5-bit sequence tag, the ackID. Upstream logic has already decoded each inbound packet. It hands the block the packet's ackID, a flag that says whether the CRC check passed, and a flag that says whether a receive buffer is free. Decoded control symbols from the far end arrive on a separate strobe.

The block keeps the ackID it expects next and decides, one item at a time, what happens to each arrival:
- **Accept:** the packet is taken.
- **Error stop:** the packet is rejected and the receiver enters error stop.
- **Retry stop:** the packet is refused for lack of a buffer and the receiver enters retry stop.
- **Drop:** the packet is discarded silently.

For each decision it requests one acknowledgement control symbol from the transmit side of the same port.

The two stop states are left by different handshakes:
- Error stop ends only when a link-request arrives. The receiver answers it with a link-response that reports the expected ackID, so the sender knows where to resume.
- Retry stop ends when a restart-from-retry symbol arrives.

Sticky "encountered" flags record that each stop state was entered. Software clears them with a write-one strobe.

Top module: `lrx_ack_ctrl`

## Requirements
- R1: In normal state, a packet with `pkt_crc_ok`=0, or a symbol with `sym_type`=3 (corrupted symbol), moves the receiver to error stop (`in_err_stop`=1) and sets `err_enc`, visible one cycle after the input.
- R2: Entering error stop issues one response with `rsp_type`=1 (packet-not-accepted) whose `rsp_ackid` is the expected ackID. Response codes are: 0 accepted, 1 not-accepted, 2 retry, 3 link-response.
- R3: While in error stop, every packet is dropped. It produces no response, no `pkt_accept` and no change to the expected ackID.
- R4: A symbol with `sym_type`=1 (link-request) in error stop produces a response with `rsp_type`=3 carrying the expected ackID, and the receiver returns to normal in the same cycle.
- R5: In normal state, a packet with good CRC and matching ackID but `pkt_buf_free`=0 is discarded. The receiver enters retry stop (`in_retry_stop`=1), sets `retry_enc` and issues a response with `rsp_type`=2 carrying the expected ackID.
- R6: A symbol with `sym_type`=2 (restart-from-retry) in retry stop returns the receiver to normal, with no response, and packets are accepted again. The same symbol in normal or error stop has no effect.
- R7: In normal state, a packet whose ackID differs from the expected ackID is treated as an error, with the same outcome as R1 and R2.
- R8: In normal state, a packet with good CRC, matching ackID and a free buffer is accepted. The block pulses `pkt_accept`, issues `rsp_type`=0 with that ackID, and increments the expected ackID by one modulo 32.
- R9: A link-request in normal or retry stop gets a link-response carrying the expected ackID, and the state does not change.
- R10: In retry stop, packets are dropped with no response. A corrupted symbol moves the receiver to error stop with a not-accepted response.
- R11: When a symbol and a packet are presented in the same cycle, the symbol is processed and the packet is discarded with no effect.
- R12: `enc_clr`=1 clears both encountered flags. A flag that is set in the same cycle stays set.
- R13: After reset the receiver is in normal state with both flags clear, no response pending and an expected ackID of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | A decoded packet is presented this cycle |
| pkt_ackid | input | 5 | ackID of the presented packet |
| pkt_crc_ok | input | 1 | Packet CRC check passed |
| pkt_buf_free | input | 1 | A receive buffer is available for the packet |
| sym_valid | input | 1 | A decoded control symbol is presented this cycle |
| sym_type | input | 2 | 0 other, 1 link-request, 2 restart-from-retry, 3 corrupted |
| enc_clr | input | 1 | Write-one clear of both encountered flags |
| rsp_valid | output | 1 | Control-symbol request valid (one-cycle pulse) |
| rsp_type | output | 2 | 0 accepted, 1 not-accepted, 2 retry, 3 link-response |
| rsp_ackid | output | 5 | ackID carried by the requested symbol |
| pkt_accept | output | 1 | Packet accepted (one-cycle pulse) |
| in_err_stop | output | 1 | Receiver is in error stop |
| in_retry_stop | output | 1 | Receiver is in retry stop |
| err_enc | output | 1 | Error stop has been entered since last clear |
| retry_enc | output | 1 | Retry stop has been entered since last clear |

## Verification
A corrupted expected ackID shows up at the ports on the very next response. Both the packet-accepted tag and the link-response ackID would then be wrong, so every later accept or link-request exposes it one cycle after the input. A wrong stop state shows within one cycle on the state outputs. It also shows as an extra or missing response when the next packet arrives: a dropped packet that gets acknowledged, or a good packet that gets no reply. The scoreboard therefore compares every response in order and flags any response that nobody expected.

// File: rtl/lrx_ack_pkg.sv
package lrx_ack_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_ERR_STOP   = 2'd1,
    ST_RETRY_STOP = 2'd2
  } lrx_state_e;

  // symbol type codes on the input port
  localparam logic [1:0] SYM_OTHER    = 2'd0;
  localparam logic [1:0] SYM_LINK_REQ = 2'd1;
  localparam logic [1:0] SYM_RESTART  = 2'd2;
  localparam logic [1:0] SYM_CORRUPT  = 2'd3;

  // response codes on the output port
  localparam logic [1:0] RSP_ACCEPT    = 2'd0;
  localparam logic [1:0] RSP_NOT_ACC   = 2'd1;
  localparam logic [1:0] RSP_RETRY     = 2'd2;
  localparam logic [1:0] RSP_LINK_RESP = 2'd3;

  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_ACCEPT   = 3'd1,
    EV_PKT_ERR  = 3'd2,
    EV_PKT_BUSY = 3'd3,
    EV_LINK_REQ = 3'd4,
    EV_RESTART  = 3'd5,
    EV_SYM_ERR  = 3'd6
  } lrx_event_e;

endpackage

// File: rtl/lrx_rst_sync.sv
module lrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lrx_ack_event.sv
module lrx_ack_event
  import lrx_ack_pkg::*;
#(
  parameter int ACKID_W = 5
) (
  input  logic               pkt_valid,
  input  logic [ACKID_W-1:0] pkt_ackid,
  input  logic               pkt_crc_ok,
  input  logic               pkt_buf_free,
  input  logic               sym_valid,
  input  logic [1:0]         sym_type,
  input  logic [ACKID_W-1:0] exp_ackid,
  output lrx_event_e         event_o
);
  logic pkt_bad;

  assign pkt_bad = !pkt_crc_ok || (pkt_ackid != exp_ackid);

  // symbols outrank packets; packet faults outrank buffer shortage
  always_comb begin
    event_o = EV_NONE;
    if (sym_valid) begin
      case (sym_type)
        SYM_LINK_REQ: event_o = EV_LINK_REQ;
        SYM_RESTART:  event_o = EV_RESTART;
        SYM_CORRUPT:  event_o = EV_SYM_ERR;
        default:      event_o = EV_NONE;
      endcase
    end else if (pkt_valid) begin
      if (pkt_bad)           event_o = EV_PKT_ERR;
      else if (!pkt_buf_free) event_o = EV_PKT_BUSY;
      else                   event_o = EV_ACCEPT;
    end
  end
endmodule

// File: rtl/lrx_ack_fsm.sv
module lrx_ack_fsm
  import lrx_ack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lrx_event_e event_i,
  output lrx_state_e state_o,
  output logic       rsp_fire,
  output logic [1:0] rsp_kind,
  output logic       accept,
  output logic       set_err,
  output logic       set_retry
);
  lrx_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    rsp_fire  = 1'b0;
    rsp_kind  = RSP_ACCEPT;
    accept    = 1'b0;
    set_err   = 1'b0;
    set_retry = 1'b0;
    case (state_q)
      ST_NORMAL: begin
        case (event_i)
          EV_ACCEPT: begin
            rsp_fire = 1'b1;
            rsp_kind = RSP_ACCEPT;
            accept   = 1'b1;
          end
          EV_PKT_ERR, EV_SYM_ERR: begin
            state_d  = ST_ERR_STOP;
            rsp_fire = 1'b1;
            rsp_kind = RSP_NOT_ACC;
            set_err  = 1'b1;
          end
          EV_PKT_BUSY: begin
            state_d   = ST_RETRY_STOP;
            rsp_fire  = 1'b1;
            rsp_kind  = RSP_RETRY;
            set_retry = 1'b1;
          end
          EV_LINK_REQ: begin
            rsp_fire = 1'b1;
            rsp_kind = RSP_LINK_RESP;
          end
          default: ;
        endcase
      end
      ST_ERR_STOP: begin
        if (event_i == EV_LINK_REQ) begin
          state_d  = ST_NORMAL;
          rsp_fire = 1'b1;
          rsp_kind = RSP_LINK_RESP;
        end
      end
      ST_RETRY_STOP: begin
        case (event_i)
          EV_LINK_REQ: begin
            rsp_fire = 1'b1;
            rsp_kind = RSP_LINK_RESP;
          end
          EV_RESTART: state_d = ST_NORMAL;
          EV_SYM_ERR: begin
            state_d  = ST_ERR_STOP;
            rsp_fire = 1'b1;
            rsp_kind = RSP_NOT_ACC;
            set_err  = 1'b1;
          end
          default: ;
        endcase
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lrx_ack_seq.sv
module lrx_ack_seq #(
  parameter int ACKID_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_en,
  output logic [ACKID_W-1:0] exp_ackid
);
  logic [ACKID_W-1:0] exp_q, exp_d;

  // wraps naturally at 2**ACKID_W
  assign exp_d = exp_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exp_q <= '0;
    else if (inc_en) exp_q <= exp_d;
  end

  assign exp_ackid = exp_q;
endmodule

// File: rtl/lrx_ack_rsp.sv
module lrx_ack_rsp #(
  parameter int ACKID_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [1:0]         kind,
  input  logic [ACKID_W-1:0] ackid,
  input  logic               accept,
  output logic               rsp_valid,
  output logic [1:0]         rsp_type,
  output logic [ACKID_W-1:0] rsp_ackid,
  output logic               pkt_accept
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      pkt_accept <= 1'b0;
    end else begin
      rsp_valid  <= fire;
      pkt_accept <= accept;
    end
  end

  // payload only loads when a response is issued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_type  <= '0;
      rsp_ackid <= '0;
    end else if (fire) begin
      rsp_type  <= kind;
      rsp_ackid <= ackid;
    end
  end
endmodule

// File: rtl/lrx_ack_sticky.sv
module lrx_ack_sticky #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_i,
  input  logic             clr_i,
  output logic [NFLAG-1:0] flag_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic flag_q, flag_d, flag_en;

    assign flag_en = set_i[g] | clr_i;
    assign flag_d  = set_i[g];   // set wins over clear

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/lrx_ack_ctrl.sv
module lrx_ack_ctrl
  import lrx_ack_pkg::*;
#(
  parameter int ACKID_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_valid,
  input  logic [ACKID_W-1:0] pkt_ackid,
  input  logic               pkt_crc_ok,
  input  logic               pkt_buf_free,
  input  logic               sym_valid,
  input  logic [1:0]         sym_type,
  input  logic               enc_clr,
  output logic               rsp_valid,
  output logic [1:0]         rsp_type,
  output logic [ACKID_W-1:0] rsp_ackid,
  output logic               pkt_accept,
  output logic               in_err_stop,
  output logic               in_retry_stop,
  output logic               err_enc,
  output logic               retry_enc
);
  localparam int NFLAG = 2;

  logic               rst_sync_n;
  logic [ACKID_W-1:0] exp_ackid;
  lrx_event_e         ev;
  lrx_state_e         state;
  logic               fire, accept, set_err, set_retry;
  logic [1:0]         kind;
  logic [NFLAG-1:0]   flags;

  lrx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lrx_ack_event #(.ACKID_W(ACKID_W)) u_event (
    .pkt_valid(pkt_valid), .pkt_ackid(pkt_ackid), .pkt_crc_ok(pkt_crc_ok),
    .pkt_buf_free(pkt_buf_free), .sym_valid(sym_valid), .sym_type(sym_type),
    .exp_ackid(exp_ackid), .event_o(ev)
  );

  lrx_ack_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .event_i(ev), .state_o(state),
    .rsp_fire(fire), .rsp_kind(kind), .accept(accept),
    .set_err(set_err), .set_retry(set_retry)
  );

  lrx_ack_seq #(.ACKID_W(ACKID_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(accept), .exp_ackid(exp_ackid)
  );

  lrx_ack_rsp #(.ACKID_W(ACKID_W)) u_rsp (
    .clk(clk), .rst_n(rst_sync_n), .fire(fire), .kind(kind),
    .ackid(exp_ackid), .accept(accept),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_ackid(rsp_ackid),
    .pkt_accept(pkt_accept)
  );

  lrx_ack_sticky #(.NFLAG(NFLAG)) u_sticky (
    .clk(clk), .rst_n(rst_sync_n), .set_i({set_retry, set_err}),
    .clr_i(enc_clr), .flag_o(flags)
  );

  assign in_err_stop   = (state == ST_ERR_STOP);
  assign in_retry_stop = (state == ST_RETRY_STOP);
  assign err_enc       = flags[0];
  assign retry_enc     = flags[1];
endmodule

// File: rtl/lrx_ack_ctrl_chk.sv
module lrx_ack_ctrl_chk #(
  parameter int ACKID_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_valid,
  input logic [ACKID_W-1:0] pkt_ackid,
  input logic               pkt_crc_ok,
  input logic               pkt_buf_free,
  input logic               sym_valid,
  input logic [1:0]         sym_type,
  input logic               rsp_valid,
  input logic [1:0]         rsp_type,
  input logic [ACKID_W-1:0] rsp_ackid,
  input logic               pkt_accept,
  input logic               in_err_stop,
  input logic               in_retry_stop,
  input logic               err_enc,
  input logic [ACKID_W-1:0] exp_ackid
);
  logic normal;
  assign normal = !in_err_stop && !in_retry_stop;

  assert_crc_err_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    normal && pkt_valid && !sym_valid && !pkt_crc_ok |=> in_err_stop && err_enc);

  assert_pna_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_err_stop) |-> rsp_valid && rsp_type == 2'd1);

  assert_drop_in_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_err_stop && pkt_valid && !sym_valid |=> !rsp_valid && !pkt_accept);

  assert_lr_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_err_stop && sym_valid && sym_type == 2'd1 |=>
      !in_err_stop && rsp_valid && rsp_type == 2'd3 && rsp_ackid == $past(exp_ackid));

  assert_retry_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    normal && pkt_valid && !sym_valid && pkt_crc_ok && pkt_ackid == exp_ackid && !pkt_buf_free
      |=> in_retry_stop && rsp_valid && rsp_type == 2'd2);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_retry_stop && sym_valid && sym_type == 2'd2 |=> !in_retry_stop && !in_err_stop);

  assert_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    normal && pkt_valid && !sym_valid && pkt_ackid != exp_ackid |=> in_err_stop);

  assert_accept_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_accept |-> rsp_valid && rsp_type == 2'd0 &&
      exp_ackid == ACKID_W'(rsp_ackid + 1'b1));

  assert_lr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    normal && sym_valid && sym_type == 2'd1 |=> !in_err_stop && !in_retry_stop && rsp_valid);

  assert_retry_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_retry_stop && pkt_valid && !sym_valid |=> !rsp_valid && in_retry_stop);

  assert_one_stop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_err_stop, in_retry_stop}));
endmodule

bind lrx_ack_ctrl lrx_ack_ctrl_chk #(.ACKID_W(ACKID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ackid(pkt_ackid),
  .pkt_crc_ok(pkt_crc_ok), .pkt_buf_free(pkt_buf_free), .sym_valid(sym_valid),
  .sym_type(sym_type), .rsp_valid(rsp_valid), .rsp_type(rsp_type),
  .rsp_ackid(rsp_ackid), .pkt_accept(pkt_accept), .in_err_stop(in_err_stop),
  .in_retry_stop(in_retry_stop), .err_enc(err_enc), .exp_ackid(exp_ackid)
);

// File: tb/lrx_ack_ctrl_bench.sv
`timescale 1ns/1ps
module lrx_ack_ctrl_bench;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 0, pkt_crc_ok = 0, pkt_buf_free = 0;
  logic [W-1:0] pkt_ackid = '0;
  logic sym_valid = 0, enc_clr = 0;
  logic [1:0] sym_type = '0;
  logic rsp_valid, pkt_accept, in_err_stop, in_retry_stop, err_enc, retry_enc;
  logic [1:0] rsp_type;
  logic [W-1:0] rsp_ackid;

  always #10 clk = ~clk;   // 50 MHz

  lrx_ack_ctrl #(.ACKID_W(W)) u_lrx_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ackid(pkt_ackid),
    .pkt_crc_ok(pkt_crc_ok), .pkt_buf_free(pkt_buf_free), .sym_valid(sym_valid),
    .sym_type(sym_type), .enc_clr(enc_clr), .rsp_valid(rsp_valid),
    .rsp_type(rsp_type), .rsp_ackid(rsp_ackid), .pkt_accept(pkt_accept),
    .in_err_stop(in_err_stop), .in_retry_stop(in_retry_stop),
    .err_enc(err_enc), .retry_enc(retry_enc)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // expected responses: {type, ackid} plus requirement tag
  logic [6:0] exp_q[$];
  string      tag_q[$];

  // reference model state, from the requirements
  int m_state = 0;           // 0 normal, 1 error stop, 2 retry stop
  logic [W-1:0] m_exp = '0;
  bit m_err = 0, m_retry = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic void push(input logic [1:0] t, input logic [W-1:0] a, input string tag);
    exp_q.push_back({t, a});
    tag_q.push_back(tag);
  endfunction

  // driver: one item per call, model computes expected outcome
  task automatic step(input bit pv, input int ack, input bit crc, input bit buf_ok,
                      input bit sv, input int st, input bit clr, input string tag);
    bit acc = 0;
    @(negedge clk);
    pkt_valid = pv; pkt_ackid = W'(ack); pkt_crc_ok = crc; pkt_buf_free = buf_ok;
    sym_valid = sv; sym_type = 2'(st); enc_clr = clr;
    if (clr) begin m_err = 0; m_retry = 0; end
    if (sv) begin
      case (st)
        1: begin push(2'd3, m_exp, tag); if (m_state == 1) m_state = 0; end
        2: if (m_state == 2) m_state = 0;
        3: if (m_state != 1) begin push(2'd1, m_exp, tag); m_state = 1; m_err = 1; end
        default: ;
      endcase
    end else if (pv && m_state == 0) begin
      if (!crc || W'(ack) != m_exp) begin
        push(2'd1, m_exp, tag); m_state = 1; m_err = 1;
      end else if (!buf_ok) begin
        push(2'd2, m_exp, tag); m_state = 2; m_retry = 1;
      end else begin
        push(2'd0, m_exp, tag); m_exp = m_exp + 1'b1; acc = 1;
      end
    end
    @(negedge clk);
    pkt_valid = 0; sym_valid = 0; enc_clr = 0;
    check({tag, " accept"}, 32'(pkt_accept), 32'(acc));
    check({tag, " err_stop"}, 32'(in_err_stop), 32'(m_state == 1));
    check({tag, " retry_stop"}, 32'(in_retry_stop), 32'(m_state == 2));
    check({tag, " err_enc"}, 32'(err_enc), 32'(m_err));
    check({tag, " retry_enc"}, 32'(retry_enc), 32'(m_retry));
  endtask

  task automatic pkt(input int ack, input bit crc, input bit buf_ok, input string tag);
    step(1, ack, crc, buf_ok, 0, 0, 0, tag);
  endtask

  task automatic sym(input int st, input string tag);
    step(0, 0, 0, 0, 1, st, 0, tag);
  endtask

  // monitor: pops and compares every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL unexpected response actual=%0h expected=none", {rsp_type, rsp_ackid});
      end else begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " response"}, 32'({rsp_type, rsp_ackid}), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 rsp_valid", 32'(rsp_valid), 0);
    check("R13 err_stop", 32'(in_err_stop), 0);
    check("R13 retry_stop", 32'(in_retry_stop), 0);
    check("R13 flags", 32'({err_enc, retry_enc}), 0);
    sym(1, "R13 expected ackid zero");

    for (int i = 0; i < 4; i++) pkt(i, 1, 1, "R8 accept");
    sym(1, "R9 link-request in normal");
    pkt(4, 0, 1, "R1 bad crc");            // R2 PNA ackid 4
    pkt(4, 1, 1, "R3 drop in error stop");
    sym(3, "R3 corrupt symbol while stopped");
    sym(2, "R6 restart ignored in error stop");
    sym(1, "R4 link-request exits error stop");
    pkt(7, 1, 1, "R7 ackid mismatch");
    sym(1, "R4 recover after mismatch");
    pkt(4, 1, 0, "R5 no buffer");
    pkt(4, 1, 1, "R10 drop in retry stop");
    sym(1, "R9 link-request in retry stop");
    sym(2, "R6 restart exits retry");
    sym(2, "R6 restart ignored in normal");
    pkt(4, 1, 1, "R6 accepted after restart");
    for (int i = 5; i < 34; i++) pkt(i % 32, 1, 1, "R8 wrap");
    sym(1, "R8 expected after wrap");
    step(1, 2, 1, 1, 1, 0, 0, "R11 symbol wins, packet discarded");
    sym(1, "R11 ackid unchanged");
    step(0, 0, 0, 0, 0, 0, 1, "R12 clear flags");
    sym(3, "R1 corrupt symbol in normal");
    sym(1, "R4 recover");
    pkt(2, 1, 0, "R5 retry again");
    sym(3, "R10 corrupt symbol in retry");
    step(1, 2, 0, 1, 0, 0, 1, "R12 clear with no set in error stop");
    sym(1, "R4 recover");
    step(1, 2, 0, 1, 0, 0, 1, "R12 set wins over clear");
    sym(1, "R4 recover");
    pkt(2, 1, 1, "R8 accept after recovery");

    repeat (4) @(negedge clk);
    check("R2 all responses seen", 32'(exp_q.size()), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule